// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit counter fed by one external input pin. It runs in one of two modes. In edge-count mode it adds one for each qualified transition on the pin. In gated-time mode it adds one on each tick of a free-running prescaler, but only while the pin sits at a selected level. The pin passes through a synchronizer before any logic uses it. The pad level always drives the counter, whatever the pin-direction bit holds.

Software reaches four byte-wide registers through a simple port: a 2-bit address, a write strobe, write data and combinational read data. The registers are a control byte, the counter, a flag byte and an interrupt-mask byte. There are two sticky flags, one for the pin edge and one for counter wrap. Writing a one to a flag clears it. Each flag drives its own interrupt request output, gated by its mask bit. A bus clock enable `ce` qualifies every state change, so the block advances only on bus cycles.

Top module: `pacc_top`

## Requirements
- R1: After reset every register reads 0x00 and both interrupt outputs are low.
- R2: Control register (address 0): bit 7 is pin direction, bit 6 is enable, bit 5 is mode (0 = edge count, 1 = gated time), bit 4 is polarity, and bits 1:0 are a stored rate field. Bits 3:2 always read 0. The mask register (address 3) keeps bits 5:4 only, and its other bits read 0.
- R3: In edge-count mode with the block enabled, the counter (address 1) adds one for each qualified edge: rising when polarity is 1, falling when polarity is 0. A pulse held for two or more bus cycles counts exactly once. The direction bit has no effect on counting.
- R4: In gated-time mode with the block enabled, the counter adds one on each prescaler tick, once every 2^PRESCALE_W bus cycles, while the synchronized pin equals the polarity bit. It does not count at the other level.
- R5: With the enable bit at 0, the counter does not change and neither flag sets.
- R6: The edge flag (flag register bit 4) sets on the counted edge in edge-count mode. In gated-time mode it sets on the trailing edge, which is falling when polarity is 1 and rising when polarity is 0.
- R7: A counter increment from 0xFF to 0x00 sets the wrap flag (flag register bit 5). Flag register bits 3:0 read 0.
- R8: Writing the flag register clears each flag whose data bit is 1 and leaves alone each flag whose data bit is 0. If a set and a clear arrive in the same cycle, the set wins.
- R9: The edge interrupt output is high exactly when the edge flag and mask bit 4 are both set. The wrap interrupt output is high exactly when the wrap flag and mask bit 5 are both set.
- R10: A write to the counter loads the written value. It overrides an increment that falls in the same cycle.
- R11: On cycles where `ce` is low, no register, flag or counter changes, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Bus clock enable; qualifies all updates |
| pin_i | input | 1 | Asynchronous accumulator input pin level |
| addr_i | input | 2 | Register select: 0 control, 1 counter, 2 flags, 3 mask |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_edge_o | output | 1 | Edge-flag interrupt request |
| irq_ovf_o | output | 1 | Wrap-flag interrupt request |

## Verification
The bench builds the block with PRESCALE_W = 3, so a gated tick comes every eight bus cycles. This makes it cheap to sweep every polarity and pin-level pair in gated-time mode, and to walk a counter write across all eight prescaler phases. The write-over-increment collision is therefore certain to be hit. Edge-count mode is swept over both polarities and several pulse counts, including a wrap from 0xFE. The gated count is also repeated with `ce` toggling to confirm the tick advances on bus cycles only.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int DATA_W  = 8;
    localparam int BIT_EVT = 4;
    localparam int BIT_OVF = 5;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ADDR_CTL = 2'd0,
        ADDR_CNT = 2'd1,
        ADDR_FLG = 2'd2,
        ADDR_MSK = 2'd3
    } addr_e;

    typedef struct packed {
        logic       dir;
        logic       en;
        logic       gated;
        logic       pol;
        logic [1:0] rate;
    } ctl_t;

    typedef struct packed {
        logic ovf;
        logic evt;
    } flags_t;

    function automatic byte_t ctl_pack(ctl_t c);
        return {c.dir, c.en, c.gated, c.pol, 2'b00, c.rate};
    endfunction

    function automatic ctl_t ctl_unpack(byte_t b);
        ctl_t c;
        c.dir   = b[7];
        c.en    = b[6];
        c.gated = b[5];
        c.pol   = b[4];
        c.rate  = b[1:0];
        return c;
    endfunction

    function automatic byte_t flags_pack(flags_t f);
        byte_t b;
        b          = '0;
        b[BIT_EVT] = f.evt;
        b[BIT_OVF] = f.ovf;
        return b;
    endfunction

    function automatic flags_t flags_unpack(byte_t b);
        flags_t f;
        f.evt = b[BIT_EVT];
        f.ovf = b[BIT_OVF];
        return f;
    endfunction

endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else if (ce) begin
            chain_q[0] <= pin_i;
            prev_q     <= chain_q[STAGES-1];
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)     chain_q[i] <= 1'b0;
                else if (ce) chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int PRESCALE_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    output logic tick_o
);
    generate
        if (PRESCALE_W == 0) begin : g_bypass
            assign tick_o = ce;
        end else begin : g_div
            logic [PRESCALE_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)     div_q <= '0;
                else if (ce) div_q <= div_q + 1'b1;
            end
            assign tick_o = ce & (&div_q);
        end
    endgenerate

endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i & ~load_i & (&cnt_q);

endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int PRESCALE_W  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       pin_i,
    input  logic [1:0] addr_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_edge_o,
    output logic       irq_ovf_o
);
    ctl_t   ctl_q;
    flags_t flag_q, flag_set, flag_clr, mask_q;
    logic   ctl_en;
    logic   flag_evt_q, flag_ovf_q;
    logic   level, rise, fall, tick;
    logic   active_edge, trailing_edge;
    logic   inc, wrap, cnt_wr;
    byte_t  cnt_q;
    addr_e  sel;

    assign sel    = addr_e'(addr_i);
    assign cnt_wr = ce & wr_i & (sel == ADDR_CNT);
    assign ctl_en = ctl_q.en;

    pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ce(ce), .pin_i(pin_i),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    pacc_prescale #(.PRESCALE_W(PRESCALE_W)) u_pre (
        .clk(clk), .rst(rst), .ce(ce), .tick_o(tick)
    );

    assign active_edge   = ctl_q.pol ? rise : fall;
    assign trailing_edge = ctl_q.pol ? fall : rise;

    always_comb begin
        inc = 1'b0;
        if (ce && ctl_q.en) begin
            if (ctl_q.gated) inc = tick & (level == ctl_q.pol);
            else             inc = active_edge;
        end
    end

    pacc_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .load_i(cnt_wr), .load_val_i(wdata_i),
        .inc_i(inc), .cnt_o(cnt_q), .wrap_o(wrap)
    );

    always_comb begin
        flag_set.ovf = wrap;
        flag_set.evt = ce & ctl_q.en & (ctl_q.gated ? trailing_edge : active_edge);
        flag_clr     = (ce && wr_i && sel == ADDR_FLG) ? flags_unpack(wdata_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            mask_q <= '0;
            flag_q <= '0;
        end else if (ce) begin
            if (wr_i && sel == ADDR_CTL) ctl_q  <= ctl_unpack(wdata_i);
            if (wr_i && sel == ADDR_MSK) mask_q <= flags_unpack(wdata_i);
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    assign flag_evt_q = flag_q.evt;
    assign flag_ovf_q = flag_q.ovf;

    always_comb begin
        unique case (sel)
            ADDR_CTL: rdata_o = ctl_pack(ctl_q);
            ADDR_CNT: rdata_o = cnt_q;
            ADDR_FLG: rdata_o = flags_pack(flag_q);
            default:  rdata_o = flags_pack(mask_q);
        endcase
    end

    assign irq_edge_o = flag_q.evt & mask_q.evt;
    assign irq_ovf_o  = flag_q.ovf & mask_q.ovf;

endmodule

// File: rtl/pacc_checker.sv
module pacc_checker (
    input logic       clk,
    input logic       rst,
    input logic       ce,
    input logic       wr_i,
    input logic [1:0] addr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] cnt_q,
    input logic       flag_evt_q,
    input logic       flag_ovf_q,
    input logic       ctl_en
);
    logic cnt_wr, flg_wr;
    assign cnt_wr = ce && wr_i && addr_i == 2'd1;
    assign flg_wr = ce && wr_i && addr_i == 2'd2;

    AST_IDLE_WITHOUT_CE: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(cnt_q) && $stable(flag_evt_q) && $stable(flag_ovf_q))); // R11

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(wdata_i))); // R10

    AST_OFF_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !cnt_wr) |=> $stable(cnt_q)); // R5

    AST_OFF_NO_EDGE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !flag_evt_q) |=> !flag_evt_q); // R5

    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        (ce && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1)); // R3

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ce && !cnt_wr && cnt_q == 8'hFF) |=> (cnt_q != 8'h00 || flag_ovf_q)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_evt_q && !(flg_wr && wdata_i[4])) |=> flag_evt_q); // R8

endmodule

bind pacc_top pacc_checker i_pacc_checker (
    .clk(clk), .rst(rst), .ce(ce), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_q(cnt_q), .flag_evt_q(flag_evt_q),
    .flag_ovf_q(flag_ovf_q), .ctl_en(ctl_en)
);

// File: tb/test_pacc_top.sv
module test_pacc_top;
    localparam int PW  = 3;
    localparam int DIV = 1 << PW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b1;
    logic       pin = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_e, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pacc_top #(.PRESCALE_W(PW), .SYNC_STAGES(2)) i_pacc_top (
        .clk(clk), .rst(rst), .ce(ce), .pin_i(pin), .addr_i(addr),
        .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_edge_o(irq_e), .irq_ovf_o(irq_o)
    );

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_test();
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulses(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); pin = ~pin;
            repeat (2) @(negedge clk);
            pin = ~pin;
            repeat (1) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) rd_check("R1", a[1:0], 8'h00);
        check("R1 irq", {6'd0, irq_e, irq_o}, 8'h00);

        // R2 control and mask readback
        wr_reg(2'd0, 8'hFF);
        rd_check("R2 ctl", 2'd0, 8'hF3);
        wr_reg(2'd0, 8'h8E);
        rd_check("R2 ctl", 2'd0, 8'h82);
        wr_reg(2'd3, 8'hFF);
        rd_check("R2 mask", 2'd3, 8'h30);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd0, 8'h00);

        // R3 / R6 edge-count sweep: polarity x pulse count, direction bit set
        for (int pol = 0; pol < 2; pol++) begin
            for (int k = 1; k <= 7; k += 3) begin
                pin = (pol == 0);
                repeat (6) @(negedge clk);
                wr_reg(2'd2, 8'h30);
                wr_reg(2'd1, 8'h00);
                wr_reg(2'd0, 8'hC0 | (pol[0] ? 8'h10 : 8'h00));
                pulses(k);
                rd_check("R3 count", 2'd1, k[7:0]);
                rd_check("R6 edge flag", 2'd2, 8'h10);
                wr_reg(2'd0, 8'h00);
            end
        end
        pin = 1'b0;
        repeat (6) @(negedge clk);

        // R5 disabled: no count, no flag
        wr_reg(2'd2, 8'h30);
        wr_reg(2'd1, 8'h21);
        wr_reg(2'd0, 8'h10);
        pulses(4);
        rd_check("R5 count", 2'd1, 8'h21);
        rd_check("R5 flag", 2'd2, 8'h00);

        // R4 gated sweep: polarity x pin level
        for (int pol = 0; pol < 2; pol++) begin
            for (int lv = 0; lv < 2; lv++) begin
                wr_reg(2'd0, 8'h00);
                pin = lv[0];
                repeat (6) @(negedge clk);
                wr_reg(2'd1, 8'h00);
                wr_reg(2'd0, 8'h60 | (pol[0] ? 8'h10 : 8'h00));
                repeat (5 * DIV - 1) @(posedge clk);
                rd_check("R4 gated", 2'd1, (pol == lv) ? 8'd5 : 8'd0);
            end
        end

        // R6 gated trailing edge, polarity 1: falling sets, rising does not
        wr_reg(2'd0, 8'h00);
        pin = 1'b0;
        repeat (6) @(negedge clk);
        wr_reg(2'd2, 8'h30);
        wr_reg(2'd0, 8'h70);
        pin = 1'b1;
        repeat (6) @(negedge clk);
        rd_check("R6 leading", 2'd2, 8'h00);
        pin = 1'b0;
        repeat (6) @(negedge clk);
        rd_check("R6 trailing", 2'd2, 8'h10);

        // R10 counter write beats increment: hold write across all prescaler phases
        pin = 1'b1;
        repeat (6) @(negedge clk);
        @(negedge clk);
        addr = 2'd1; wdata = 8'h40; wr = 1'b1;
        for (int i = 0; i < DIV + 1; i++) begin
            @(posedge clk);
            @(negedge clk); #1;
            check("R10 write priority", rdata, 8'h40);
        end
        wr = 1'b0;

        // R11 ce toggling: gated tick advances on bus cycles only
        wr_reg(2'd1, 8'h00);
        @(negedge clk);
        for (int i = 0; i < 2 * 3 * DIV; i++) begin
            ce = ~ce;
            @(negedge clk);
        end
        ce = 1'b1;
        addr = 2'd1; #1;
        check("R11 half-rate gated", rdata, 8'd3);
        // R11 write with ce low ignored
        wr_reg(2'd0, 8'h00);
        @(negedge clk);
        ce = 1'b0; addr = 2'd1; wdata = 8'h99; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; ce = 1'b1;
        rd_check("R11 write blocked", 2'd1, 8'd3);

        // R7 / R9 wrap
        pin = 1'b0;
        repeat (6) @(negedge clk);
        wr_reg(2'd2, 8'h30);
        wr_reg(2'd1, 8'hFE);
        wr_reg(2'd0, 8'h50);
        pulses(1);
        rd_check("R7 no wrap yet", 2'd2, 8'h10);
        pulses(1);
        rd_check("R7 count", 2'd1, 8'h00);
        rd_check("R7 flag", 2'd2, 8'h30);
        check("R9 masked off", {6'd0, irq_e, irq_o}, 8'h00);
        wr_reg(2'd3, 8'h20);
        #1 check("R9 ovf irq", {6'd0, irq_e, irq_o}, 8'h01);
        wr_reg(2'd3, 8'h30);
        #1 check("R9 both irq", {6'd0, irq_e, irq_o}, 8'h03);

        // R8 write-one-to-clear
        wr_reg(2'd2, 8'h0F);
        rd_check("R8 zero write", 2'd2, 8'h30);
        wr_reg(2'd2, 8'h20);
        rd_check("R8 clear ovf", 2'd2, 8'h10);
        #1 check("R9 edge irq", {6'd0, irq_e, irq_o}, 8'h02);
        wr_reg(2'd2, 8'h10);
        rd_check("R8 clear edge", 2'd2, 8'h00);

        done = 1'b1;
        finish_test();
    end
endmodule